// File: doc/BRIEF.md
# Four-Bit Single-Cycle Processor

This block is a small processor core that executes one instruction on every rising clock edge. It has no pipeline. A 3-bit program counter selects one of eight 12-bit words from a constant program store. The word is decoded in the same cycle. The result is written back to a file of eight 4-bit registers on the following edge. The program store is a module parameter, so a different program is loaded by overriding that parameter when the core is instantiated.

The instruction set has four operations: add two registers, negate a register, load a 4-bit immediate, and branch when a register holds zero. Register 0 always reads as zero, which turns the conditional branch into an unconditional one. Only three values leave the core: a zero flag, a carry flag and the contents of register 7. The two flags hold the outcome of the most recent add or negate.

Top module: `nibble_cpu`

## Requirements
- R1: While `rst` is high at a rising edge, the PC, every register and both flags are cleared to zero. Execution then restarts from address 0.
- R2: Opcode `2'b10` (bits [11:10]) loads the immediate in bits [3:0] into the register addressed by bits [9:7]. It leaves both flags unchanged.
- R3: Opcode `2'b00` writes (Ra + Rb) mod 16 into Ra, where Ra is addressed by bits [9:7] and Rb by bits [6:4]. `carry_o` becomes the carry out of bit 3, and `zero_o` goes high exactly when the 4-bit result is 0.
- R4: Opcode `2'b01` writes 0 − Ra (two's complement, computed as 0 + ~Ra + 1) into Ra. `carry_o` is 1 only when Ra was 0, and `zero_o` follows the result.
- R5: Opcode `2'b11` loads the PC with bits [2:0] when Ra is zero, and with PC+1 otherwise. It writes no register and leaves both flags unchanged.
- R6: Register 0 always reads 0; a write addressed to it has no effect.
- R7: Sequential execution wraps the PC from 7 to 0.
- R8: With the default program, `r7_o` reads 0, 0, 0, 1, 3, 6 after the first six edges following reset. It then holds 6 forever, because address 6 branches to itself.
- R9: Each instruction completes in exactly one clock cycle. Its register result is visible on the ports right after the edge that executes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| zero_o | output | 1 | Set when the last add/negate result was zero |
| carry_o | output | 1 | Carry out of bit 3 of the last add/negate |
| r7_o | output | 4 | Current contents of register 7 |

## Verification
Two pairs of functions can collide in one edge. The first pair is a branch test and the sequential wrap. The second pair is an arithmetic write and a flag update that a later non-arithmetic instruction must preserve.

A mixed program places a failing branch on a nonzero register just before an add at address 7 that overflows to zero. It then lets the PC wrap onto an immediate load. The bench judges both the fall-through and the wrap by the exact sequence of `r7_o` values. It also checks that the carry and zero flags from address 7 are still present after the load at address 0.

A second program negates a zero register and then branches on it, to show that the skipped loads never reach `r7_o`.

// File: rtl/nibble_cpu.sv
module nibble_cpu #(
  parameter int DW = 4,
  parameter int AW = 3,
  parameter int IW = 2 + 2*AW + DW,
  parameter logic [IW*(2**AW)-1:0] PROGRAM = {
    12'h000, 12'hC06, 12'h3B0, 12'h3A0,
    12'h390, 12'h983, 12'h902, 12'h881}
)(
  input  logic          clk,
  input  logic          rst,
  output logic          zero_o,
  output logic          carry_o,
  output logic [DW-1:0] r7_o
);

  localparam int NREG = 2**AW;
  localparam logic [1:0] OP_ADD = 2'b00;
  localparam logic [1:0] OP_NEG = 2'b01;
  localparam logic [1:0] OP_MOV = 2'b10;
  localparam logic [1:0] OP_JZR = 2'b11;

  logic [AW-1:0] pc;
  logic [IW-1:0] instr;
  logic [1:0]    op;
  logic [AW-1:0] ra, rb;
  logic [DW-1:0] imm;
  logic [DW-1:0] regs [NREG];
  logic [DW-1:0] opa, opb, a_in, b_in, bx, sum;
  logic [DW:0]   cy;
  logic          sub, arith, wr_en, take;
  logic [DW-1:0] wdata;
  logic [AW-1:0] pc_next;

  assign instr = PROGRAM[pc*IW +: IW];
  assign op    = instr[IW-1 -: 2];
  assign ra    = instr[IW-3 -: AW];
  assign rb    = instr[IW-3-AW -: AW];
  assign imm   = instr[DW-1:0];

  assign opa = regs[ra];
  assign opb = regs[rb];

  assign sub   = (op == OP_NEG);
  assign arith = (op == OP_ADD) || (op == OP_NEG);
  assign a_in  = sub ? '0 : opa;
  assign b_in  = sub ? opa : opb;
  assign bx    = b_in ^ {DW{sub}};
  assign cy[0] = sub;

  for (genvar gi = 0; gi < DW; gi++) begin : g_fa
    assign sum[gi]  = a_in[gi] ^ bx[gi] ^ cy[gi];
    assign cy[gi+1] = (a_in[gi] & bx[gi]) | (cy[gi] & (a_in[gi] ^ bx[gi]));
  end

  assign wdata   = (op == OP_MOV) ? imm : sum;
  assign wr_en   = (op != OP_JZR) && (ra != '0);
  assign take    = (op == OP_JZR) && (opa == '0);
  assign pc_next = take ? imm[AW-1:0] : pc + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= '0;
      zero_o  <= 1'b0;
      carry_o <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      pc <= pc_next;
      if (wr_en) regs[ra] <= wdata;
      if (arith) begin
        zero_o  <= (sum == '0);
        carry_o <= cy[DW];
      end
    end
  end

  assign r7_o = regs[NREG-1];

  a_r6_r0_zero: assert property (@(posedge clk) disable iff (rst)
    regs[0] == '0);

  a_r2_mov_flags: assert property (@(posedge clk) disable iff (rst)
    (op == OP_MOV) |=> ($stable(zero_o) && $stable(carry_o)));

  a_r5_jump_quiet: assert property (@(posedge clk) disable iff (rst)
    (op == OP_JZR) |=> ($stable(r7_o) && $stable(zero_o) && $stable(carry_o)));

  a_r5_jump_target: assert property (@(posedge clk) disable iff (rst)
    take |=> (pc == $past(imm[AW-1:0])));

  a_r7_pc_wrap: assert property (@(posedge clk) disable iff (rst)
    (!take && pc == '1) |=> (pc == '0));

  a_r4_neg_carry: assert property (@(posedge clk) disable iff (rst)
    (op == OP_NEG) |=> (carry_o == ($past(opa) == '0)));

endmodule

// File: tb/nibble_cpu_tb.sv
module nibble_cpu_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  localparam logic [95:0] PROG_MIX = {
    12'h390, 12'h882, 12'hF80, 12'h780,
    12'h380, 12'h805, 12'h3F0, 12'hB89};
  localparam logic [95:0] PROG_JMP = {
    12'hB8F, 12'hB8F, 12'hC05, 12'hB85,
    12'hB8F, 12'hB8F, 12'hF84, 12'h780};

  logic       z_d, c_d, z_m, c_m, z_j, c_j;
  logic [3:0] r_d, r_m, r_j;

  nibble_cpu dut_i (.clk(clk), .rst(rst), .zero_o(z_d), .carry_o(c_d), .r7_o(r_d));
  nibble_cpu #(.PROGRAM(PROG_MIX)) dut_mix (.clk(clk), .rst(rst), .zero_o(z_m), .carry_o(c_m), .r7_o(r_m));
  nibble_cpu #(.PROGRAM(PROG_JMP)) dut_jmp (.clk(clk), .rst(rst), .zero_o(z_j), .carry_o(c_j), .r7_o(r_j));

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  task automatic check(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_default_program();
    int exp_r7 [12] = '{0, 0, 0, 1, 3, 6, 6, 6, 6, 6, 6, 6};
    do_reset();
    check("R1", "r7 after reset", r_d, 0);
    check("R1", "zero after reset", z_d, 0);
    check("R1", "carry after reset", c_d, 0);
    for (int k = 0; k < 12; k++) begin
      step();
      check(k < 6 ? "R8" : "R8/R5", "default r7", r_d, exp_r7[k]);
      if (k == 3) check("R9", "r7 right after first add", r_d, 1);
    end
    check("R3", "zero after 0+..=6", z_d, 0);
    check("R3", "carry after sum 6", c_d, 0);
  endtask

  task automatic t_mixed_program();
    int er [10] = '{9, 2, 2, 2, 14, 14, 14, 0, 9, 2};
    int ec [10] = '{0, 1, 1, 0, 0, 0, 0, 1, 1, 1};
    int ez [10] = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 0};
    do_reset();
    for (int k = 0; k < 10; k++) begin
      step();
      check("R2/R3/R6", "mix r7", r_m, er[k]);
      check("R3/R4", "mix carry", c_m, ec[k]);
      check("R3/R4", "mix zero", z_m, ez[k]);
    end
    // R6: the add of R0 after writing 5 to it leaves r7 at 2
    // R7: step 9 re-executes address 0 (r7 back to 9, flags kept)
  endtask

  task automatic t_jump_program();
    int er [6] = '{0, 0, 5, 5, 5, 5};
    do_reset();
    for (int k = 0; k < 6; k++) begin
      step();
      check("R5", "jump r7", r_j, er[k]);
      check("R4", "neg of zero carry", c_j, 1);
      check("R4", "neg of zero flag", z_j, 1);
    end
  endtask

  task automatic t_reset_midrun();
    do_reset();
    repeat (8) step();
    check("R1", "mix carry set before reset", c_m, 1);
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    check("R1", "r7 cleared midrun", r_d, 0);
    check("R1", "carry cleared midrun", c_m, 0);
    check("R1", "zero cleared midrun", z_m, 0);
    rst = 1'b0;
    repeat (4) step();
    check("R1", "restart from address 0", r_d, 1);
  endtask

  initial begin
    t_default_program();
    t_mixed_program();
    t_jump_program();
    t_reset_midrun();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule